// File: doc/BRIEF.md
# Sixteen-Bit Two-Level Lookahead Adder

This block is a purely combinational binary adder. It takes two 16-bit operands and a carry input, and it returns a 16-bit sum and a carry output. No carry ripples across the word.

The datapath is split into four 4-bit groups. Each group forms a generate term and an inclusive-OR propagate term for every bit. From these it produces flattened sum-of-products carries for its own bits. It also exports one block generate and one block propagate. A second lookahead level uses those block terms and the carry input to build the carries into bits 4, 8 and 12 and the final carry output. Each of those carries is a sum of products that uses only block terms and the carry input.

Because the propagate term is an OR, each sum bit uses a separate exclusive-OR of the operand bits. The worst path runs through both lookahead levels and ends at the top sum bit.

Top module: `gcla_adder16`

## Requirements
- R1: For every input combination, the 17-bit value {cout, sum} equals a + b + cin.
- R2: All-ones operand handling: 0xFFFF + 0x0000 with cin=1, and 0xFFFF + 0x0001 with cin=0, both give sum 0x0000 with cout 1.
- R3: A carry that starts inside one group reaches the next group. Examples: 0x000F+0x0001 gives 0x0010, 0x00FF+0x0001 gives 0x0100, 0x0FFF+0x0001 gives 0x1000, 0x7FFF+0x0001 gives 0x8000, each with cout 0.
- R4: The carry that the second level delivers into each group boundary equals the carry out that the lower group computes from its own bits and its own carry in.
- R5: cout equals the top-level block generate OR (top-level block propagate AND cin). This covers a carry generated in the top group (0xF000+0x1000 gives sum 0, cout 1) and a carry-in that propagates through all groups (0xFFFF+0x0000, cin=1).
- R6: Zero operands with cin=0 give sum 0x0000 and cout 0; zero operands with cin=1 give sum 0x0001 and cout 0.
- R7: Alternating patterns: 0x5555+0xAAAA gives 0xFFFF with cout 0 when cin=0, and 0x0000 with cout 1 when cin=1. 0xAAAA+0xAAAA gives 0x5554 with cout 1.
- R8: The outputs depend only on the current inputs. A new input value shows at sum and cout in the same time step, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 16 | First operand |
| b | input | 16 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| cout | output | 1 | Carry out of bit 15 |

## Verification
Two carry sources can act at the same time. The first is a carry generated inside one group. The second is a carry-in that the second level passes through a chain of all-propagate groups. Both can reach the same group boundary, or cout, in one evaluation. Vectors such as 0x0FFF+0x0001 with cin=1 and 0xFFFF+0x0001 with cin=1 fire both sources together. The bench judges each result against a behavioural 17-bit addition. The bound checker separately compares every boundary carry with the carry out that the lower group computes on its own.

// File: rtl/gcla_pkg.sv
package gcla_pkg;

    localparam int ADD_W   = 16;
    localparam int GRP_W   = 4;
    localparam int LA_MAX  = 16;

    typedef struct packed {
        logic gen;
        logic prop;
    } blk_term_t;

    // Flattened lookahead carry into position 'upto': sum of products of
    // generate/propagate terms plus the fully propagated carry input.
    function automatic logic la_carry(input logic [LA_MAX-1:0] g,
                                      input logic [LA_MAX-1:0] p,
                                      input logic              c,
                                      input int                upto);
        logic acc;
        logic prod;
        acc = 1'b0;
        for (int j = 0; j < LA_MAX; j++) begin
            if (j < upto) begin
                prod = g[j];
                for (int m = 0; m < LA_MAX; m++) begin
                    if (m > j && m < upto) prod = prod & p[m];
                end
                acc = acc | prod;
            end
        end
        prod = c;
        for (int m = 0; m < LA_MAX; m++) begin
            if (m < upto) prod = prod & p[m];
        end
        return acc | prod;
    endfunction

endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead
    import gcla_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         cin,
    output logic [N-1:0] carry_in,
    output logic         carry_out,
    output blk_term_t    blk
);

    logic [LA_MAX-1:0] g_ext;
    logic [LA_MAX-1:0] p_ext;

    assign g_ext = LA_MAX'(gen);
    assign p_ext = LA_MAX'(prop);

    assign carry_in[0] = cin;

    genvar k;
    generate
        for (k = 1; k < N; k++) begin : g_carry
            assign carry_in[k] = la_carry(g_ext, p_ext, cin, k);
        end
    endgenerate

    assign carry_out = la_carry(g_ext, p_ext, cin, N);
    assign blk.gen   = la_carry(g_ext, p_ext, 1'b0, N);
    assign blk.prop  = &prop;

endmodule

// File: rtl/cla_group.sv
module cla_group
    import gcla_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output blk_term_t    blk,
    output logic         local_cout
);

    logic [W-1:0] bit_gen;
    logic [W-1:0] bit_prop;
    logic [W-1:0] bit_half;
    logic [W-1:0] bit_carry;

    assign bit_gen  = a & b;
    assign bit_prop = a | b;
    assign bit_half = a ^ b;

    cla_lookahead #(.N(W)) u_la (
        .gen       (bit_gen),
        .prop      (bit_prop),
        .cin       (cin),
        .carry_in  (bit_carry),
        .carry_out (local_cout),
        .blk       (blk)
    );

    assign sum = bit_half ^ bit_carry;

endmodule

// File: rtl/gcla_adder16.sv
module gcla_adder16
    import gcla_pkg::*;
#(
    parameter int WIDTH   = ADD_W,
    parameter int GROUP_W = GRP_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int N_GRP = WIDTH / GROUP_W;

    blk_term_t  grp_blk [N_GRP];
    logic [N_GRP-1:0] grp_gen;
    logic [N_GRP-1:0] grp_prop;
    logic [N_GRP-1:0] grp_cin;
    logic [N_GRP-1:0] grp_lcout;
    blk_term_t        top_blk;

    genvar gi;
    generate
        for (gi = 0; gi < N_GRP; gi++) begin : g_grp
            cla_group #(.W(GROUP_W)) u_grp (
                .a          (a[gi*GROUP_W +: GROUP_W]),
                .b          (b[gi*GROUP_W +: GROUP_W]),
                .cin        (grp_cin[gi]),
                .sum        (sum[gi*GROUP_W +: GROUP_W]),
                .blk        (grp_blk[gi]),
                .local_cout (grp_lcout[gi])
            );
            assign grp_gen[gi]  = grp_blk[gi].gen;
            assign grp_prop[gi] = grp_blk[gi].prop;
        end
    endgenerate

    cla_lookahead #(.N(N_GRP)) u_top_la (
        .gen       (grp_gen),
        .prop      (grp_prop),
        .cin       (cin),
        .carry_in  (grp_cin),
        .carry_out (cout),
        .blk       (top_blk)
    );

endmodule

// File: rtl/gcla_adder16_chk.sv
module gcla_adder16_chk #(
    parameter int WIDTH = 16,
    parameter int N_GRP = 4
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [N_GRP-1:0] grp_cin,
    input logic [N_GRP-1:0] grp_lcout,
    input logic [N_GRP-1:0] grp_gen,
    input logic [N_GRP-1:0] grp_prop,
    input logic             top_gen,
    input logic             top_prop
);

    always_comb begin
        // R1
        p_sum_match_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}))
            else $error("sum mismatch");
        // R5
        p_top_cout_r5: assert (cout == (top_gen | (top_prop & cin)))
            else $error("top carry mismatch");
        // R4: boundary carries agree with each group's own carry out
        for (int k = 0; k < N_GRP - 1; k++) begin
            p_boundary_carry_r4: assert (grp_cin[k+1] == grp_lcout[k])
                else $error("boundary carry %0d mismatch", k);
        end
        p_last_carry_r4: assert (cout == grp_lcout[N_GRP-1])
            else $error("last group carry mismatch");
        // R3: a group that neither generates nor propagates kills its carry
        for (int k = 0; k < N_GRP; k++) begin
            p_kill_blocks_r3: assert (grp_gen[k] || grp_prop[k] || !grp_lcout[k])
                else $error("group %0d carries without gen/prop", k);
        end
    end

endmodule

bind gcla_adder16 gcla_adder16_chk #(.WIDTH(WIDTH), .N_GRP(N_GRP)) u_chk (
    .a         (a),
    .b         (b),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .grp_cin   (grp_cin),
    .grp_lcout (grp_lcout),
    .grp_gen   (grp_gen),
    .grp_prop  (grp_prop),
    .top_gen   (top_blk.gen),
    .top_prop  (top_blk.prop)
);

// File: tb/gcla_adder16_tb.sv
module gcla_adder16_tb;

    logic        clk = 1'b0;
    logic [15:0] a   = '0;
    logic [15:0] b   = '0;
    logic        cin = 1'b0;
    logic [15:0] sum;
    logic        cout;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    gcla_adder16 u_dut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic apply_check(input logic [15:0] va, input logic [15:0] vb,
                               input logic vc, input logic [16:0] exp_v,
                               input string req);
        a   = va;
        b   = vb;
        cin = vc;
        #1;
        n_checks++;
        if ({cout, sum} !== exp_v) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b actual=%h expected=%h",
                     req, va, vb, vc, {cout, sum}, exp_v);
        end
    endtask

    task automatic t_zero();
        apply_check(16'h0000, 16'h0000, 1'b0, 17'h00000, "R6");
        apply_check(16'h0000, 16'h0000, 1'b1, 17'h00001, "R6");
    endtask

    task automatic t_all_ones();
        apply_check(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R2");
        apply_check(16'hFFFF, 16'h0001, 1'b0, 17'h10000, "R2");
        apply_check(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R1");
    endtask

    task automatic t_boundaries();
        apply_check(16'h000F, 16'h0001, 1'b0, 17'h00010, "R3");
        apply_check(16'h00FF, 16'h0001, 1'b0, 17'h00100, "R3");
        apply_check(16'h0FFF, 16'h0001, 1'b0, 17'h01000, "R3");
        apply_check(16'h7FFF, 16'h0001, 1'b0, 17'h08000, "R3");
        // R4: group 0 carry reaches bit 4 from cin alone
        apply_check(16'h000F, 16'h0000, 1'b1, 17'h00010, "R4");
        apply_check(16'h0FFF, 16'h0001, 1'b1, 17'h01001, "R4");
        apply_check(16'h00F0, 16'h0010, 1'b0, 17'h00100, "R4");
    endtask

    task automatic t_top_carry();
        apply_check(16'hF000, 16'h1000, 1'b0, 17'h10000, "R5");
        apply_check(16'hFFFF, 16'h0001, 1'b1, 17'h10001, "R5");
        apply_check(16'h8000, 16'h8000, 1'b0, 17'h10000, "R5");
    endtask

    task automatic t_alternating();
        apply_check(16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF, "R7");
        apply_check(16'h5555, 16'hAAAA, 1'b1, 17'h10000, "R7");
        apply_check(16'hAAAA, 16'hAAAA, 1'b0, 17'h15554, "R7");
    endtask

    task automatic t_no_clock();
        // R8: inputs change mid-phase; result checked 1 time unit later
        @(posedge clk);
        #3;
        apply_check(16'h1234, 16'h4321, 1'b0, 17'h05555, "R8");
        apply_check(16'h1234, 16'h4321, 1'b1, 17'h05556, "R8");
    endtask

    task automatic t_random();
        for (int i = 0; i < 400; i++) begin
            logic [15:0] ra;
            logic [15:0] rb;
            logic        rc;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rc = 1'($urandom);
            apply_check(ra, rb, rc, {1'b0, ra} + {1'b0, rb} + {16'h0, rc}, "R1");
            #2;
        end
    endtask

    initial begin
        #5;
        t_zero();
        t_all_ones();
        t_boundaries();
        t_top_carry();
        t_alternating();
        t_no_clock();
        t_random();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule